// File: doc/BRIEF.md
# PHY Basic Control Register with MAC-Side Pin Control

This block holds the basic control register of an Ethernet PHY management space and turns its bits into controls for the MAC-facing data path. A management front end hands it already-decoded 16-bit register writes and reads. Select 0 addresses the control register. Select 1 addresses a status word that holds latching-high and latching-low status bits. The control register holds four bits: auto-negotiation enable (bit 12), low power (bit 11), isolate (bit 10) and restart auto-negotiation (bit 9). All other control bits read as zero.

The block drives three controls onto the MAC-side pins:
- an output enable, which turns the pins to high impedance when low;
- a force-low control;
- a pass gate for the MAC-side inputs.

It also issues a one-cycle restart pulse to the auto-negotiation engine and waits for that engine's acknowledge. A small state machine tracks each restart. In state IDLE no restart is outstanding. The transition IDLE→PULSE happens on an accepted restart write. In PULSE the restart pulse is high for one cycle, and the transition PULSE→WAIT_ACK is unconditional. In WAIT_ACK the block holds bit 9 at one. The transition WAIT_ACK→IDLE happens on the engine's acknowledge. Bit 9 reads one in PULSE and WAIT_ACK, and zero in IDLE.

Top module: `phy_ctrl_reg`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the bits as follows:
  - bit 12 is set to 1.
  - bits 11 and 9 are set to 0.
  - bit 10 is set to 1 when phy_addr equals 5'b00000, and to 0 otherwise.
  - every latching-high status bit is set to 0.
  - every latching-low status bit is set to 1.
  With the default widths, the status word reads 16'h00F0 after reset.
- R2: A write with reg_sel=0 loads bits 12, 11 and 10 from wdata. The new values appear on rdata (reg_sel=0) in the next cycle. All control bits other than 12, 11, 10 and 9 read 0. Writes with reg_sel=1 change nothing.
- R3: While bit 10 is 1, mac_oe is 0, so the MAC-side outputs are at high impedance. mac_in_en is also 0, so the MAC-side inputs are blocked.
- R4: While bit 11 is 1 and bit 10 is 0, mac_force_low is 1 and mac_oe stays 1, so the outputs are driven low. mac_in_en is 0.
- R5: Isolate takes priority over low power. When both bits are 1, mac_force_low is 0 and mac_oe is 0.
- R6: A control write with wdata[12]=1 and wdata[9]=1 made in state IDLE starts a restart. an_restart is high for exactly the next cycle, and bit 9 reads 1 from that cycle on.
- R7: Bit 9 reads 0 from the cycle after the cycle in which an_ack is sampled high in WAIT_ACK. Until then bit 9 stays 1, and a second restart write is ignored.
- R8: A control write with wdata[12]=0 and wdata[9]=1 produces no an_restart pulse, and bit 9 stays 0.
- R9: A latching-high status bit (status bit i for lh_evt[i]) becomes 1 after any cycle with its event high. It stays 1 until a status read (rd_en with reg_sel=1). The read returns the latched 1 and clears the bit afterwards. An event in the same cycle as the read wins, so the bit stays 1.
- R10: A latching-low status bit (status bit NUM_LH+j for ll_cond[j]) becomes 0 after any cycle with its condition low. It stays 0 until a status read. The read returns the 0 and sets the bit back to 1 afterwards, unless the condition is still low.
- R11: A control write that changes bit 11 from 0 to 1 returns every latching status bit to its reset value, and this overrides any same-cycle event. All control bits keep the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr | input | ADDR_W | Strapped PHY address, sampled during reset |
| reg_sel | input | 1 | 0 = control register, 1 = status word |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears latches when reg_sel=1 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| lh_evt | input | NUM_LH | Latching-high event inputs |
| ll_cond | input | NUM_LL | Latching-low condition inputs (low = event) |
| an_ack | input | 1 | Auto-negotiation engine start acknowledge |
| an_restart | output | 1 | One-cycle restart pulse |
| mac_oe | output | 1 | MAC-side output enable (0 = high impedance) |
| mac_force_low | output | 1 | Force MAC-side outputs low |
| mac_in_en | output | 1 | MAC-side input pass gate (0 = blocked) |

## Verification
The pin controls are tried with each combination of the isolate and low-power bits. The combination with both bits set shows whether isolate has priority over force-low. Restart writes are made with auto-negotiation enabled and with it disabled, and the number of pulses and the moment bit 9 clears relative to the acknowledge are checked. This tells a pulse that lasts too long apart from a restart that was wrongly accepted. The latches are exercised with single events, with read-clear, and with a low-power entry over pending events. Reset is applied with a zero strap and with a non-zero strap to separate the two isolate defaults.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
    localparam int REG_W    = 16;
    localparam int BIT_ANEN = 12;
    localparam int BIT_LP   = 11;
    localparam int BIT_ISO  = 10;
    localparam int BIT_RST  = 9;

    typedef enum logic [1:0] {
        AN_IDLE     = 2'd0,
        AN_PULSE    = 2'd1,
        AN_WAIT_ACK = 2'd2
    } an_state_t;
endpackage

// File: rtl/phy_latch_status.sv
module phy_latch_status #(
    parameter int NUM_LH = 4,
    parameter int NUM_LL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_clr,
    input  logic              rd_clr,
    input  logic [NUM_LH-1:0] lh_evt,
    input  logic [NUM_LL-1:0] ll_cond,
    output logic [NUM_LH-1:0] lh_q,
    output logic [NUM_LL-1:0] ll_q
);
    for (genvar i = 0; i < NUM_LH; i++) begin : g_lh
        always_ff @(posedge clk) begin
            if (!rst_n || lp_clr) lh_q[i] <= 1'b0;
            else if (lh_evt[i])   lh_q[i] <= 1'b1;
            else if (rd_clr)      lh_q[i] <= 1'b0;
        end
    end

    for (genvar j = 0; j < NUM_LL; j++) begin : g_ll
        always_ff @(posedge clk) begin
            if (!rst_n || lp_clr) ll_q[j] <= 1'b1;
            else if (!ll_cond[j]) ll_q[j] <= 1'b0;
            else if (rd_clr)      ll_q[j] <= 1'b1;
        end
    end

    // R11: low-power entry restores latch defaults
    assert_lp_clears_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lp_clr |=> (lh_q == '0 && ll_q == '1));
    // R9: an event is always captured
    assert_lh_captures_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lh_evt != '0 && !lp_clr) |=> ((lh_q & $past(lh_evt)) == $past(lh_evt)));
endmodule

// File: rtl/phy_an_restart.sv
module phy_an_restart
    import phy_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic an_ack,
    output logic an_restart,
    output logic busy
);
    an_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= AN_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt  = state;
        an_restart = 1'b0;
        busy       = 1'b1;
        unique case (state)
            AN_IDLE: begin
                busy = 1'b0;
                if (start_req) state_nxt = AN_PULSE;
            end
            AN_PULSE: begin
                an_restart = 1'b1;
                state_nxt  = AN_WAIT_ACK;
            end
            AN_WAIT_ACK: begin
                if (an_ack) state_nxt = AN_IDLE;
            end
            default: state_nxt = AN_IDLE;
        endcase
    end

    // R6: restart pulse lasts a single cycle
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> !an_restart);
    // R7: acknowledge in WAIT_ACK clears the busy bit next cycle
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AN_WAIT_ACK && an_ack) |=> !busy);
endmodule

// File: rtl/phy_pin_ctrl.sv
module phy_pin_ctrl (
    input  logic iso,
    input  logic lp,
    output logic mac_oe,
    output logic mac_force_low,
    output logic mac_in_en
);
    always_comb begin
        mac_oe        = !iso;
        mac_force_low = lp && !iso;
        mac_in_en     = !iso && !lp;
    end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NUM_LH = 4,
    parameter int NUM_LL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [NUM_LH-1:0] lh_evt,
    input  logic [NUM_LL-1:0] ll_cond,
    input  logic              an_ack,
    output logic              an_restart,
    output logic              mac_oe,
    output logic              mac_force_low,
    output logic              mac_in_en
);
    localparam int STAT_BITS = NUM_LH + NUM_LL;

    logic ctrl_anen, ctrl_lp, ctrl_iso, an_busy;
    logic ctrl_wr, start_req, lp_clr, rd_clr;
    logic [NUM_LH-1:0] lh_q;
    logic [NUM_LL-1:0] ll_q;
    logic unused_wdata;

    assign unused_wdata = ^{wdata[REG_W-1:BIT_ANEN+1], wdata[BIT_RST-1:0]};
    assign ctrl_wr   = wr_en && !reg_sel;
    assign start_req = ctrl_wr && wdata[BIT_ANEN] && wdata[BIT_RST];
    assign lp_clr    = ctrl_wr && wdata[BIT_LP] && !ctrl_lp;
    assign rd_clr    = rd_en && reg_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_anen <= 1'b1;
            ctrl_lp   <= 1'b0;
            ctrl_iso  <= (phy_addr == '0);
        end else if (ctrl_wr) begin
            ctrl_anen <= wdata[BIT_ANEN];
            ctrl_lp   <= wdata[BIT_LP];
            ctrl_iso  <= wdata[BIT_ISO];
        end
    end

    phy_an_restart u_an (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .an_ack(an_ack),
        .an_restart(an_restart), .busy(an_busy)
    );

    phy_latch_status #(.NUM_LH(NUM_LH), .NUM_LL(NUM_LL)) u_lat (
        .clk(clk), .rst_n(rst_n), .lp_clr(lp_clr), .rd_clr(rd_clr),
        .lh_evt(lh_evt), .ll_cond(ll_cond), .lh_q(lh_q), .ll_q(ll_q)
    );

    phy_pin_ctrl u_pins (
        .iso(ctrl_iso), .lp(ctrl_lp),
        .mac_oe(mac_oe), .mac_force_low(mac_force_low), .mac_in_en(mac_in_en)
    );

    always_comb begin
        rdata = '0;
        if (reg_sel) begin
            rdata[STAT_BITS-1:0] = {ll_q, lh_q};
        end else begin
            rdata[BIT_ANEN] = ctrl_anen;
            rdata[BIT_LP]   = ctrl_lp;
            rdata[BIT_ISO]  = ctrl_iso;
            rdata[BIT_RST]  = an_busy;
        end
    end

    initial begin
        assert_stat_fits_R2: assert (STAT_BITS <= REG_W);
    end

    // R3: isolate releases outputs and blocks inputs
    assert_iso_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_iso |-> (!mac_oe && !mac_in_en));
    // R4: low power without isolate forces outputs low
    assert_lp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_lp && !ctrl_iso) |-> (mac_force_low && mac_oe && !mac_in_en));
    // R5: force-low never acts on released outputs
    assert_iso_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mac_force_low |-> mac_oe);
    // R8: restart rejected while auto-negotiation disabled
    assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[BIT_ANEN] && !an_busy) |=> !an_restart);
endmodule

// File: tb/phy_ctrl_reg_tb.sv
module phy_ctrl_reg_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] phy_addr = 5'd0;
    logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0] lh_evt = '0;
    logic [3:0] ll_cond = '1;
    logic an_ack = 1'b0;
    logic an_restart, mac_oe, mac_force_low, mac_in_en;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phy_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_sel(reg_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .lh_evt(lh_evt), .ll_cond(ll_cond), .an_ack(an_ack),
        .an_restart(an_restart), .mac_oe(mac_oe),
        .mac_force_low(mac_force_low), .mac_in_en(mac_in_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] addr);
        @(negedge clk);
        phy_addr = addr; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_ctrl(input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b1; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] v);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic t_reset_defaults;
        logic [15:0] v;
        do_reset(5'd0);
        rd_reg(1'b0, v); chk("R1 ctrl addr0", v, 16'h1400);
        chk("R1 oe addr0", {15'd0, mac_oe}, 16'd0);
        rd_reg(1'b1, v); chk("R1 status", v, 16'h00F0);
        do_reset(5'd5);
        rd_reg(1'b0, v); chk("R1 ctrl addr5", v, 16'h1000);
        chk("R1 pins addr5", {13'd0, mac_oe, mac_force_low, mac_in_en}, 16'b101);
    endtask

    task automatic t_write_iso;
        logic [15:0] v;
        wr_ctrl(16'hFFFF & ~16'h1A00);
        rd_reg(1'b0, v); chk("R2 readback", v, 16'h0400);
        chk("R3 iso pins", {13'd0, mac_oe, mac_force_low, mac_in_en}, 16'b000);
        @(negedge clk); reg_sel = 1'b1; wr_en = 1'b1; wdata = 16'h0000;
        @(negedge clk); wr_en = 1'b0; reg_sel = 1'b0;
        rd_reg(1'b0, v); chk("R2 status write ignored", v, 16'h0400);
    endtask

    task automatic t_low_power;
        logic [15:0] v;
        @(negedge clk); lh_evt[2] = 1'b1; ll_cond[1] = 1'b0;
        @(negedge clk); lh_evt[2] = 1'b0; ll_cond[1] = 1'b1;
        wr_ctrl(16'h1800);
        chk("R4 lp pins", {13'd0, mac_oe, mac_force_low, mac_in_en}, 16'b110);
        rd_reg(1'b1, v); chk("R11 latches cleared", v, 16'h00F0);
        rd_reg(1'b0, v); chk("R11 ctrl kept", v, 16'h1800);
        wr_ctrl(16'h1C00);
        chk("R5 priority pins", {13'd0, mac_oe, mac_force_low, mac_in_en}, 16'b000);
        wr_ctrl(16'h1000);
        chk("R4 lp exit pins", {13'd0, mac_oe, mac_force_low, mac_in_en}, 16'b101);
    endtask

    task automatic t_restart;
        logic [15:0] v;
        int pulses = 0;
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b1; wdata = 16'h1200;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
        chk("R6 pulse cycle", {15'd0, an_restart}, 16'd1);
        #1 chk("R6 bit9 set", rdata & 16'h0200, 16'h0200);
        @(negedge clk);
        chk("R6 pulse ends", {15'd0, an_restart}, 16'd0);
        wr_ctrl(16'h1200);
        chk("R7 no second pulse", {15'd0, an_restart}, 16'd0);
        rd_reg(1'b0, v); chk("R7 bit9 held", v, 16'h1200);
        @(negedge clk); an_ack = 1'b1;
        #1 chk("R7 bit9 before ack edge", rdata & 16'h0200, 16'h0200);
        @(negedge clk); an_ack = 1'b0;
        #1 chk("R7 bit9 cleared", rdata & 16'h0200, 16'h0000);
        wr_ctrl(16'h0200);
        for (int k = 0; k < 4; k++) begin
            if (an_restart) pulses++;
            @(negedge clk);
        end
        chk("R8 no pulse", pulses[15:0], 16'd0);
        rd_reg(1'b0, v); chk("R8 bit9 zero", v, 16'h0000);
    endtask

    task automatic t_latches;
        logic [15:0] v;
        @(negedge clk); lh_evt[1] = 1'b1;
        @(negedge clk); lh_evt[1] = 1'b0;
        rd_reg(1'b1, v); chk("R9 lh set", v, 16'h00F2);
        rd_reg(1'b1, v); chk("R9 lh cleared", v, 16'h00F0);
        @(negedge clk); reg_sel = 1'b1; rd_en = 1'b1; lh_evt[3] = 1'b1;
        @(negedge clk); rd_en = 1'b0; lh_evt[3] = 1'b0;
        rd_reg(1'b1, v); chk("R9 event beats read", v, 16'h00F8);
        rd_reg(1'b1, v);
        @(negedge clk); ll_cond[0] = 1'b0;
        @(negedge clk); ll_cond[0] = 1'b1;
        rd_reg(1'b1, v); chk("R10 ll low", v, 16'h00E0);
        rd_reg(1'b1, v); chk("R10 ll restored", v, 16'h00F0);
    endtask

    initial begin
        t_reset_defaults();
        t_write_iso();
        t_low_power();
        t_restart();
        t_latches();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule